// File: doc/BRIEF.md
# Branch and Jump Resolution Unit

This combinational unit sits in the execute path of a 32-bit integer core. In one evaluation it decides whether the instruction being resolved changes control flow and, if it does, where fetch goes next. It takes the decoder's branch and jump control bits, a three-bit condition code, the two source register values, the address of the instruction (PC) and the raw instruction word. It returns a redirect flag and a destination address.

The unit rebuilds the branch and jump immediates from the instruction word itself, so the decoder does not have to carry them. A single adder forms every destination. The base is either the PC or the first register operand, and the offset is selected from the branch immediate, the jump immediate, the I-format immediate or the constant 4. A register-indirect jump has bit 0 of its sum forced to zero. The condition comparator can be built either around one shared subtractor or from separate comparators, chosen by a parameter.

Top module: `brj_unit`

## Requirements
- R1: When both `ctl_branch` and `ctl_jump` are 0, `redirect` is 0 and `dest_addr` equals `cur_pc + 4`, whatever the other inputs are.
- R2: When `ctl_jump` is 1, `redirect` is 1 regardless of `cond_code`, `ctl_branch` and the operand values.
- R3: With `ctl_branch`=1 and `ctl_jump`=0, code 0 makes `redirect` equal to (`opnd_a == opnd_b`), and code 1 makes it equal to (`opnd_a != opnd_b`).
- R4: With `ctl_branch`=1 and `ctl_jump`=0, code 2 gives signed `opnd_a >= opnd_b`, and code 3 gives signed `opnd_a < opnd_b`.
- R5: With `ctl_branch`=1 and `ctl_jump`=0, code 4 gives unsigned `opnd_a >= opnd_b`, and code 5 gives unsigned `opnd_a < opnd_b`.
- R6: With `ctl_branch`=1 and `ctl_jump`=0, code 6 always redirects and code 7 never does.
- R7: With `ctl_branch`=1 and `ctl_jump`=0, `dest_addr` is `cur_pc` plus the sign-extended 13-bit offset {instr[31], instr[7], instr[30:25], instr[11:8], 0}, whether or not the branch is taken.
- R8: With `ctl_jump`=1 and an instruction word that is not a register-indirect jump, `dest_addr` is `cur_pc` plus the sign-extended 21-bit offset {instr[31], instr[19:12], instr[20], instr[30:25], instr[24:21], 0}. This includes opcode 1101111.
- R9: With `ctl_jump`=1 and instr[6:0]=1100111 and instr[14:12]=000, `dest_addr` is (`opnd_a` + sign-extended instr[31:20]) with bit 0 cleared.
- R10: When both control bits are 1, the jump rules (R2, R8, R9) apply and the branch condition and branch offset are ignored.
- R11: An instruction with opcode 1100111 but a nonzero instr[14:12] is not treated as a register-indirect jump. Under `ctl_jump`=1 it takes the R8 destination.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ctl_branch | input | 1 | Decoder says this is a conditional branch |
| ctl_jump | input | 1 | Decoder says this is an unconditional jump |
| cond_code | input | 3 | Condition selector: 0 eq, 1 ne, 2 ge signed, 3 lt signed, 4 ge unsigned, 5 lt unsigned, 6 always, 7 never |
| opnd_a | input | 32 | First source register value |
| opnd_b | input | 32 | Second source register value |
| cur_pc | input | 32 | Address of the instruction being resolved |
| instr | input | 32 | Raw instruction word |
| redirect | output | 1 | Control flow leaves the sequential path |
| dest_addr | output | 32 | Next fetch address |

## Verification
The block holds no state, so every fault shows up in the same evaluation as the stimulus that exercises it. A wrongly wired immediate bit, a swapped signed or unsigned compare, or a wrong base or offset selection appears at once as a wrong `redirect` or `dest_addr`. Random operands are biased toward equal values and toward sign-boundary pairs, so that the equality and ordering decisions are exercised at their edges. Random instruction words reach every immediate bit, and directed vectors cover the indirect-jump decode and the priority of the jump bit.

// File: rtl/brj_pkg.sv
package brj_pkg;
    localparam int ILEN = 32;

    typedef enum logic [2:0] {
        CC_EQ   = 3'd0,
        CC_NE   = 3'd1,
        CC_GES  = 3'd2,
        CC_LTS  = 3'd3,
        CC_GEU  = 3'd4,
        CC_LTU  = 3'd5,
        CC_ALL  = 3'd6,
        CC_NONE = 3'd7
    } cond_e;

    localparam logic [6:0] OPC_JREG = 7'b1100111;
    localparam logic [2:0] F3_JREG  = 3'b000;
endpackage

// File: rtl/brj_imm_extract.sv
module brj_imm_extract
    import brj_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [ILEN-1:0] instr,
    output logic [XLEN-1:0] imm_b,
    output logic [XLEN-1:0] imm_j,
    output logic [XLEN-1:0] imm_i
);
    localparam int BW = 13;
    localparam int JW = 21;
    localparam int IW = 12;

    logic [BW-1:0] raw_b;
    logic [JW-1:0] raw_j;
    logic [IW-1:0] raw_i;

    always_comb begin
        raw_b = {instr[31], instr[7], instr[30:25], instr[11:8], 1'b0};
        raw_j = {instr[31], instr[19:12], instr[20], instr[30:25], instr[24:21], 1'b0};
        raw_i = instr[31:20];
        imm_b = {{(XLEN-BW){raw_b[BW-1]}}, raw_b};
        imm_j = {{(XLEN-JW){raw_j[JW-1]}}, raw_j};
        imm_i = {{(XLEN-IW){raw_i[IW-1]}}, raw_i};
    end
endmodule

// File: rtl/brj_compare.sv
module brj_compare
    import brj_pkg::*;
#(
    parameter int XLEN       = 32,
    parameter bit SHARED_SUB = 1'b1
) (
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    input  cond_e           code,
    output logic            cond_true
);
    localparam int MSB = XLEN - 1;

    logic eq, lt_s, lt_u;

    assign eq = (a == b);

    generate
        if (SHARED_SUB) begin : g_shared
            logic [XLEN:0] diff;
            assign diff = {1'b0, a} - {1'b0, b};
            assign lt_u = diff[XLEN];
            assign lt_s = (a[MSB] ^ b[MSB]) ? a[MSB] : diff[MSB];
        end else begin : g_direct
            assign lt_u = (a < b);
            assign lt_s = ($signed(a) < $signed(b));
        end
    endgenerate

    always_comb begin
        unique case (code)
            CC_EQ:   cond_true = eq;
            CC_NE:   cond_true = !eq;
            CC_GES:  cond_true = !lt_s;
            CC_LTS:  cond_true = lt_s;
            CC_GEU:  cond_true = !lt_u;
            CC_LTU:  cond_true = lt_u;
            CC_ALL:  cond_true = 1'b1;
            default: cond_true = 1'b0;
        endcase
    end

    always_comb begin
        if (!$isunknown({a, b})) begin
            if (eq) AST_EQ_NOT_LESS: assert (!lt_s && !lt_u); // R3
        end
    end
endmodule

// File: rtl/brj_target.sv
module brj_target
    import brj_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic            sel_branch,
    input  logic            sel_jump,
    input  logic            sel_jreg,
    input  logic [XLEN-1:0] pc,
    input  logic [XLEN-1:0] rs1,
    input  logic [XLEN-1:0] imm_b,
    input  logic [XLEN-1:0] imm_j,
    input  logic [XLEN-1:0] imm_i,
    output logic [XLEN-1:0] dest
);
    localparam logic [XLEN-1:0] STEP = XLEN'(4);

    logic            use_reg;
    logic [XLEN-1:0] base, offs, sum;

    always_comb begin
        use_reg = sel_jump && sel_jreg;
        base    = use_reg ? rs1 : pc;
        if (use_reg)         offs = imm_i;
        else if (sel_jump)   offs = imm_j;
        else if (sel_branch) offs = imm_b;
        else                 offs = STEP;
        sum  = base + offs;
        dest = use_reg ? {sum[XLEN-1:1], 1'b0} : sum;
    end
endmodule

// File: rtl/brj_unit.sv
module brj_unit
    import brj_pkg::*;
#(
    parameter int XLEN       = 32,
    parameter bit SHARED_SUB = 1'b1
) (
    input  logic            ctl_branch,
    input  logic            ctl_jump,
    input  logic [2:0]      cond_code,
    input  logic [XLEN-1:0] opnd_a,
    input  logic [XLEN-1:0] opnd_b,
    input  logic [XLEN-1:0] cur_pc,
    input  logic [ILEN-1:0] instr,
    output logic            redirect,
    output logic [XLEN-1:0] dest_addr
);
    logic [XLEN-1:0] imm_b, imm_j, imm_i;
    logic            cond_true;
    logic            is_jreg;

    assign is_jreg = (instr[6:0] == OPC_JREG) && (instr[14:12] == F3_JREG);

    brj_imm_extract #(.XLEN(XLEN)) u_imm (
        .instr (instr),
        .imm_b (imm_b),
        .imm_j (imm_j),
        .imm_i (imm_i)
    );

    brj_compare #(.XLEN(XLEN), .SHARED_SUB(SHARED_SUB)) u_cmp (
        .a         (opnd_a),
        .b         (opnd_b),
        .code      (cond_e'(cond_code)),
        .cond_true (cond_true)
    );

    brj_target #(.XLEN(XLEN)) u_tgt (
        .sel_branch (ctl_branch),
        .sel_jump   (ctl_jump),
        .sel_jreg   (is_jreg),
        .pc         (cur_pc),
        .rs1        (opnd_a),
        .imm_b      (imm_b),
        .imm_j      (imm_j),
        .imm_i      (imm_i),
        .dest       (dest_addr)
    );

    assign redirect = ctl_jump || (ctl_branch && cond_true);

    always_comb begin
        if (!$isunknown({ctl_branch, ctl_jump, cond_code, opnd_a, opnd_b, cur_pc, instr})) begin
            if (!ctl_branch && !ctl_jump) AST_IDLE_NO_REDIRECT: assert (!redirect); // R1
            if (!ctl_branch && !ctl_jump) AST_IDLE_SEQ_DEST: assert (dest_addr == cur_pc + XLEN'(4)); // R1
            if (ctl_jump) AST_JUMP_REDIRECTS: assert (redirect); // R2
            if (ctl_jump && is_jreg) AST_JREG_EVEN: assert (dest_addr[0] == 1'b0); // R9
            if (ctl_branch && !ctl_jump && cond_code == 3'd7) AST_NEVER_CODE: assert (!redirect); // R6
        end
    end
endmodule

// File: tb/sim_brj_unit.sv
module sim_brj_unit;
    logic        clk = 1'b0;
    logic        ctl_branch, ctl_jump;
    logic [2:0]  cond_code;
    logic [31:0] opnd_a, opnd_b, cur_pc, instr;
    logic        redirect;
    logic [31:0] dest_addr;

    int n_checks = 0;
    int n_errors = 0;
    int cycles   = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;

    brj_unit u0 (
        .ctl_branch (ctl_branch),
        .ctl_jump   (ctl_jump),
        .cond_code  (cond_code),
        .opnd_a     (opnd_a),
        .opnd_b     (opnd_b),
        .cur_pc     (cur_pc),
        .instr      (instr),
        .redirect   (redirect),
        .dest_addr  (dest_addr)
    );

    function automatic logic exp_taken(logic br, logic jp, logic [2:0] cc,
                                       logic [31:0] a, logic [31:0] b);
        logic c;
        if (jp) return 1'b1;
        if (!br) return 1'b0;
        case (cc)
            3'd0: c = (a == b);
            3'd1: c = (a != b);
            3'd2: c = ($signed(a) >= $signed(b));
            3'd3: c = ($signed(a) < $signed(b));
            3'd4: c = (a >= b);
            3'd5: c = (a < b);
            3'd6: c = 1'b1;
            default: c = 1'b0;
        endcase
        return c;
    endfunction

    function automatic logic [31:0] exp_dest(logic br, logic jp, logic [31:0] a,
                                             logic [31:0] pc, logic [31:0] iw);
        logic [31:0] ob, oj, oi, s;
        ob = {{19{iw[31]}}, iw[31], iw[7], iw[30:25], iw[11:8], 1'b0};
        oj = {{11{iw[31]}}, iw[31], iw[19:12], iw[20], iw[30:25], iw[24:21], 1'b0};
        oi = {{20{iw[31]}}, iw[31:20]};
        if (jp && iw[6:0] == 7'b1100111 && iw[14:12] == 3'b000) begin
            s = a + oi;
            return s & 32'hFFFF_FFFE;
        end
        if (jp) return pc + oj;
        if (br) return pc + ob;
        return pc + 32'd4;
    endfunction

    function automatic string tag_for(logic br, logic jp, logic [2:0] cc, logic [31:0] iw);
        if (jp && br) return "R10";
        if (jp && iw[6:0] == 7'b1100111 && iw[14:12] == 3'b000) return "R9";
        if (jp && iw[6:0] == 7'b1100111) return "R11";
        if (jp) return "R8";
        if (!br) return "R1";
        case (cc)
            3'd0, 3'd1: return "R3";
            3'd2, 3'd3: return "R4";
            3'd4, 3'd5: return "R5";
            default:    return "R6";
        endcase
    endfunction

    task automatic apply(logic br, logic jp, logic [2:0] cc, logic [31:0] a,
                         logic [31:0] b, logic [31:0] pc, logic [31:0] iw);
        logic        et;
        logic [31:0] ed;
        string       t;
        @(negedge clk);
        ctl_branch = br; ctl_jump = jp; cond_code = cc;
        opnd_a = a; opnd_b = b; cur_pc = pc; instr = iw;
        #2;
        et = exp_taken(br, jp, cc, a, b);
        ed = exp_dest(br, jp, a, pc, iw);
        t  = tag_for(br, jp, cc, iw);
        n_checks++;
        if (redirect !== et) begin
            n_errors++;
            $display("FAIL %s redirect actual=%0b expected=%0b", t, redirect, et);
        end
        n_checks++;
        if (dest_addr !== ed) begin
            n_errors++;
            // branch-only vectors check the R7 offset as well as the condition
            $display("FAIL %s%s dest actual=%h expected=%h", t,
                     (br && !jp) ? "/R7" : "", dest_addr, ed);
        end
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000 && !done) begin
            n_errors++;
            n_checks++;
            $display("FAIL watchdog actual=%0d expected<=100000", cycles);
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        ctl_branch = 0; ctl_jump = 0; cond_code = 0;
        opnd_a = 0; opnd_b = 0; cur_pc = 0; instr = 0;
        void'($urandom(32'd20240611));

        // R1 idle state and idle with junk inputs
        apply(0, 0, 3'd0, 32'd0, 32'd0, 32'h0000_1000, 32'h0);
        apply(0, 0, 3'd6, 32'h5, 32'h5, 32'hFFFF_FFFC, 32'hFFFF_FFFF);
        // R3
        apply(1, 0, 3'd0, 32'h1234, 32'h1234, 32'h100, 32'h0000_0063);
        apply(1, 0, 3'd1, 32'h1234, 32'h1234, 32'h100, 32'h0000_1063);
        // R4 sign boundary
        apply(1, 0, 3'd3, 32'h8000_0000, 32'h7FFF_FFFF, 32'h200, 32'h0);
        apply(1, 0, 3'd2, 32'hFFFF_FFFF, 32'h0, 32'h200, 32'h0);
        // R5 same operands, unsigned view
        apply(1, 0, 3'd5, 32'h7FFF_FFFF, 32'h8000_0000, 32'h200, 32'h0);
        apply(1, 0, 3'd4, 32'h8000_0000, 32'h8000_0000, 32'h200, 32'h0);
        // R6
        apply(1, 0, 3'd6, 32'h1, 32'h2, 32'h300, 32'h0);
        apply(1, 0, 3'd7, 32'h1, 32'h1, 32'h300, 32'h0);
        // R7 negative branch offset, all offset bits set
        apply(1, 0, 3'd0, 32'h0, 32'h0, 32'h0001_0000, 32'hFE00_0FE3);
        // R8 JAL with negative offset
        apply(0, 1, 3'd0, 32'h0, 32'h0, 32'h0002_0000, 32'hFFFF_F06F);
        // R9 indirect jump, odd sum
        apply(0, 1, 3'd0, 32'h0000_1001, 32'h0, 32'h400, 32'h0020_0067);
        apply(0, 1, 3'd0, 32'h0000_1000, 32'h0, 32'h400, 32'hFFF0_0067);
        // R11 indirect opcode, funct3 nonzero
        apply(0, 1, 3'd0, 32'h0000_1000, 32'h0, 32'h400, 32'h0020_1067);
        // R10 both bits, condition false
        apply(1, 1, 3'd7, 32'h1, 32'h2, 32'h500, 32'h0100_006F);

        for (int k = 0; k < 3000; k++) begin
            logic [31:0] a, b, iw;
            logic        br, jp;
            logic [2:0]  sel;
            a   = $urandom;
            b   = $urandom;
            sel = 3'($urandom % 8);
            if (sel == 0) b = a;
            if (sel == 1) begin a = {1'b1, a[30:0]}; b = {1'b0, b[30:0]}; end
            iw  = $urandom;
            if (sel == 2) iw = {iw[31:15], 3'b000, iw[11:7], 7'b1100111};
            if (sel == 3) iw = {iw[31:7], 7'b1101111};
            br  = 1'($urandom % 2);
            jp  = ($urandom % 4) == 0;
            apply(br, jp, 3'($urandom % 8), a, b, $urandom, iw);
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule